// File: doc/BRIEF.md
# Dual Timer/Counter with Shared Mode Register

This block holds two timer/counter channels. Each channel has a low count byte and a high count byte. One 8-bit configuration byte sets both channels: the upper nibble configures channel 1 and the lower nibble configures channel 0. A channel advances either on a prescaled tick supplied from outside or on falling edges of its own external count pin. A channel can also be gated by the level of an external interrupt line.

Each channel has four counting modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a fourth mode whose meaning depends on the channel. In the fourth mode, channel 0 splits into two separate 8-bit counters, and channel 1 stops and holds its count. Run bits and sticky overflow flags sit in a control byte. All bytes are written through a single write port and read back through a combinational read port.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset every register reads zero. Registers are selected by address: 0 configuration, 1 control, 2 channel-0 low byte, 3 channel-0 high byte, 4 channel-1 low byte, 5 channel-1 high byte. Addresses 6 and 7 read zero. Configuration bit layout: bit 7 ch1 gate, bit 6 ch1 pin select, bits 5:4 ch1 mode, bit 3 ch0 gate, bit 2 ch0 pin select, bits 1:0 ch0 mode. Control byte layout: bit 0 run0, bit 1 run1, bit 2 flag0, bit 3 flag1. A written value takes effect at the next clock edge.
- R2: A channel advances only while its run bit is 1. When its gate bit is 1, it also needs its interrupt line to equal its polarity input (1 means active high).
- R3: With pin select 0, a channel advances on each cycle that the tick input is high. With pin select 1, it advances once per high-to-low transition of its count pin. That count lands at the third rising edge at which the pin is sampled low.
- R4: Mode 0 (13-bit): bits 4:0 of the low byte count and carry into the high byte. Low-byte bits 7:5 hold their value. The wrap from all ones to zero sets the channel's flag.
- R5: Mode 1 (16-bit): the high and low bytes form one counter. The wrap from 0xFFFF to 0 sets the flag.
- R6: Mode 2 (8-bit reload): the low byte counts. When it advances at 0xFF, it loads the high byte and the flag sets in that same edge.
- R7: Channel 0 in mode 3 splits in two. The low byte follows channel 0's gate, select and run controls and sets flag0. The high byte counts tick cycles while run1 is 1, and its wrap sets flag1.
- R8: Channel 1 in mode 3 holds both of its bytes.
- R9: A write to a count byte wins over an increment in the same cycle. A write to either byte suppresses that counter's overflow in that cycle. In split mode, each half is suppressed only by a write to its own byte.
- R10: Flags stay set until the control byte is written. An overflow in the same cycle as that write still sets the flag.
- R11: While channel 0 is in mode 3, a wrap of channel 1 does not set flag1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timer tick, one-cycle enable |
| ext_cnt | input | 2 | External count pins, bit i for channel i |
| ext_irq | input | 2 | Interrupt lines used for gating |
| irq_act_hi | input | 2 | Active level of each interrupt line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ovf_flag | output | 2 | Overflow flags of channels 0 and 1 |

## Verification
The bench uses the default parameters: 8-bit count bytes, a 5-bit prescale field for 13-bit mode, and a two-flop pin synchronizer. With these values a 13-bit or 8-bit wrap is only a few increments away once the bytes are preloaded through the write port. Random runs therefore reach every mode's overflow, reload and split behaviour many times, without long idle counting. The short synchronizer also keeps the three-edge pin latency small enough to check directly.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int BYTE_W    = 8;
    localparam int LO_PRE_W  = 5;
    localparam int ADDR_W    = 3;
    localparam int CHANNELS  = 2;

    typedef enum logic [1:0] {
        TM_13    = 2'd0,
        TM_16    = 2'd1,
        TM_8RL   = 2'd2,
        TM_SPLIT = 2'd3
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     ext_sel;
        tc_mode_e mode;
    } tc_chan_cfg_t;

    typedef struct packed {
        tc_chan_cfg_t t1;
        tc_chan_cfg_t t0;
    } tc_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG  = 3'd0,
        RA_CTRL = 3'd1,
        RA_LO0  = 3'd2,
        RA_HI0  = 3'd3,
        RA_LO1  = 3'd4,
        RA_HI1  = 3'd5
    } tc_addr_e;

    function automatic logic chan_enable(input logic run, input logic gate,
                                         input logic irq, input logic act_hi);
        return run & (~gate | (irq == act_hi));
    endfunction

endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], pin};
            prev <= sh[STAGES-1];
        end
    end

    assign fall = prev & ~sh[STAGES-1];
endmodule

// File: rtl/tc_count_unit.sv
module tc_count_unit
    import tc_pkg::*;
#(
    parameter int W     = 8,
    parameter int PRE_W = 5,
    parameter bit SPLIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  tc_mode_e     mode,
    input  logic         adv,
    input  logic         hi_adv,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf,
    output logic         hi_ovf
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;
    localparam logic [W-1:0]     B_MAX   = '1;
    localparam logic [2*W-1:0]   W_ONE   = 1;

    logic [W-1:0] lo_n, hi_n;
    logic         ovf_raw, hi_ovf_raw;
    logic         split_on;

    assign split_on = SPLIT && (mode == TM_SPLIT);

    always_comb begin
        lo_n       = lo_q;
        hi_n       = hi_q;
        ovf_raw    = 1'b0;
        hi_ovf_raw = 1'b0;
        unique case (mode)
            TM_13: begin
                if (adv) begin
                    lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                    if (lo_q[PRE_W-1:0] == PRE_MAX) begin
                        hi_n    = hi_q + 1'b1;
                        ovf_raw = (hi_q == B_MAX);
                    end
                end
            end
            TM_16: begin
                if (adv) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + W_ONE;
                    ovf_raw      = &{hi_q, lo_q};
                end
            end
            TM_8RL: begin
                if (adv) begin
                    if (lo_q == B_MAX) begin
                        lo_n    = hi_q;
                        ovf_raw = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            TM_SPLIT: begin
                if (SPLIT) begin
                    if (adv) begin
                        lo_n    = lo_q + 1'b1;
                        ovf_raw = (lo_q == B_MAX);
                    end
                    if (hi_adv) begin
                        hi_n       = hi_q + 1'b1;
                        hi_ovf_raw = (hi_q == B_MAX);
                    end
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    assign ovf    = ovf_raw & ~wr_lo & (split_on | ~wr_hi);
    assign hi_ovf = hi_ovf_raw & ~wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
    import tc_pkg::*;
#(
    parameter int W           = tc_pkg::BYTE_W,
    parameter int PRE_W       = tc_pkg::LO_PRE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        ext_cnt,
    input  logic [1:0]        ext_irq,
    input  logic [1:0]        irq_act_hi,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [1:0]        ovf_flag
);
    localparam int NCH = tc_pkg::CHANNELS;

    tc_cfg_t                  cfg_q;
    logic [NCH-1:0]           run_q;
    logic [NCH-1:0]           flag_q;
    tc_chan_cfg_t [NCH-1:0]   ch_cfg;
    logic [NCH-1:0]           fall;
    logic [NCH-1:0]           adv;
    logic [NCH-1:0]           hi_adv;
    logic [NCH-1:0]           wr_lo, wr_hi;
    logic [NCH-1:0]           ovf, hi_ovf;
    logic [NCH-1:0][W-1:0]    cnt_lo, cnt_hi;
    logic [NCH-1:0]           flag_set;
    logic                     wr_cfg, wr_ctrl;

    assign ch_cfg[0] = cfg_q.t0;
    assign ch_cfg[1] = cfg_q.t1;

    assign wr_cfg   = wr_en && (wr_addr == RA_CFG);
    assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign wr_lo[0] = wr_en && (wr_addr == RA_LO0);
    assign wr_hi[0] = wr_en && (wr_addr == RA_HI0);
    assign wr_lo[1] = wr_en && (wr_addr == RA_LO1);
    assign wr_hi[1] = wr_en && (wr_addr == RA_HI1);

    // Channel 0's high half borrows channel 1's run bit in split mode.
    assign hi_adv[0] = run_q[1] & tick;
    assign hi_adv[1] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_cnt[i]),
            .fall (fall[i])
        );

        assign adv[i] = chan_enable(run_q[i], ch_cfg[i].gate, ext_irq[i], irq_act_hi[i])
                        & (ch_cfg[i].ext_sel ? fall[i] : tick);

        tc_count_unit #(.W(W), .PRE_W(PRE_W), .SPLIT(i == 0)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .mode    (ch_cfg[i].mode),
            .adv     (adv[i]),
            .hi_adv  (hi_adv[i]),
            .wr_lo   (wr_lo[i]),
            .wr_hi   (wr_hi[i]),
            .wr_data (wr_data),
            .lo_q    (cnt_lo[i]),
            .hi_q    (cnt_hi[i]),
            .ovf     (ovf[i]),
            .hi_ovf  (hi_ovf[i])
        );
    end

    assign flag_set[0] = ovf[0];
    assign flag_set[1] = hi_ovf[0] | hi_ovf[1] | (ovf[1] & (ch_cfg[0].mode != TM_SPLIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= tc_cfg_t'(wr_data[7:0]);
            if (wr_ctrl) run_q <= wr_data[1:0];
            flag_q <= (wr_ctrl ? wr_data[3:2] : flag_q) | flag_set;
        end
    end

    always_comb begin
        case (tc_addr_e'(rd_addr))
            RA_CFG:  rd_data = W'(cfg_q);
            RA_CTRL: rd_data = W'({flag_q, run_q});
            RA_LO0:  rd_data = cnt_lo[0];
            RA_HI0:  rd_data = cnt_hi[0];
            RA_LO1:  rd_data = cnt_lo[1];
            RA_HI1:  rd_data = cnt_hi[1];
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/tc_checker.sv
module tc_checker
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [W-1:0]          wr_data,
    input logic [1:0]            ext_irq,
    input logic [1:0]            irq_act_hi,
    input tc_cfg_t               cfg_q,
    input logic [1:0]            run_q,
    input logic [1:0]            flag_q,
    input logic [1:0][W-1:0]     cnt_lo,
    input logic [1:0][W-1:0]     cnt_hi,
    input logic [1:0]            adv
);
    logic wl0, wh0, wc1, wctl;
    assign wl0  = wr_en && (wr_addr == RA_LO0);
    assign wh0  = wr_en && (wr_addr == RA_HI0);
    assign wc1  = wr_en && ((wr_addr == RA_LO1) || (wr_addr == RA_HI1));
    assign wctl = wr_en && (wr_addr == RA_CTRL);

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == RA_CFG) |=> cfg_q == tc_cfg_t'($past(wr_data[7:0]))); // R1

    AST_NO_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run_q[0] && !wl0 |=> $stable(cnt_lo[0])); // R2

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        cfg_q.t0.gate && (ext_irq[0] != irq_act_hi[0]) && !wl0 |=> $stable(cnt_lo[0])); // R2

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.t0.mode == TM_8RL) && (cnt_lo[0] == '1) && adv[0] && !wl0 && !wh0
        |=> (cnt_lo[0] == $past(cnt_hi[0])) && flag_q[0]); // R6

    AST_T1_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.t1.mode == TM_SPLIT) && !wc1 |=> $stable(cnt_lo[1]) && $stable(cnt_hi[1])); // R8

    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        wl0 |=> cnt_lo[0] == $past(wr_data)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q[0] && !wctl |=> flag_q[0]); // R10
endmodule

bind dual_timer_counter tc_checker #(.W(W)) u_chk (.*);

// File: tb/sim_dual_timer_counter.sv
module sim_dual_timer_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] ext_cnt = 2'b11;
    logic [1:0] ext_irq = 2'b00;
    logic [1:0] irq_act_hi = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic [1:0] ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dual_timer_counter u0 (
        .clk(clk), .rst(rst), .tick(tick), .ext_cnt(ext_cnt), .ext_irq(ext_irq),
        .irq_act_hi(irq_act_hi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_cfg;
    logic [1:0] m_run, m_flag, m_s0, m_s1, m_pv;
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];

    function automatic logic [17:0] step(input logic [1:0] md, input bit split,
            input logic a, input logic ha, input logic [7:0] lo, input logic [7:0] hi,
            input logic wl, input logic wh, input logic [7:0] wd);
        logic [7:0] nlo, nhi;
        logic o, ho;
        nlo = lo; nhi = hi; o = 1'b0; ho = 1'b0;
        case (md)
            2'd0: if (a) begin
                if (lo[4:0] == 5'h1f) begin o = (hi == 8'hff); nhi = hi + 8'd1; end
                nlo = {lo[7:5], lo[4:0] + 5'd1};
            end
            2'd1: if (a) begin
                {nhi, nlo} = {hi, lo} + 16'd1;
                o = ({hi, lo} == 16'hffff);
            end
            2'd2: if (a) begin
                if (lo == 8'hff) begin nlo = hi; o = 1'b1; end
                else nlo = lo + 8'd1;
            end
            default: if (split) begin
                if (a)  begin nlo = lo + 8'd1; o  = (lo == 8'hff); end
                if (ha) begin nhi = hi + 8'd1; ho = (hi == 8'hff); end
            end
        endcase
        if (wl) nlo = wd;
        if (wh) nhi = wd;
        if (md == 2'd3 && split) begin o = o & ~wl; ho = ho & ~wh; end
        else o = o & ~(wl | wh);
        return {o, ho, nlo, nhi};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg;
            3'd1: return {4'd0, m_flag, m_run};
            3'd2: return m_lo[0];
            3'd3: return m_hi[0];
            3'd4: return m_lo[1];
            3'd5: return m_hi[1];
            default: return 8'd0;
        endcase
    endfunction

    logic [17:0] r0, r1;
    logic [1:0]  mf, ma;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 8'd0; m_run = 2'd0; m_flag = 2'd0;
            m_s0 = 2'd0; m_s1 = 2'd0; m_pv = 2'd0;
            m_lo[0] = 8'd0; m_lo[1] = 8'd0; m_hi[0] = 8'd0; m_hi[1] = 8'd0;
        end else begin
            mf = m_pv & ~m_s1;
            for (int i = 0; i < 2; i++)
                ma[i] = m_run[i] & (~m_cfg[4*i+3] | (ext_irq[i] == irq_act_hi[i]))
                        & (m_cfg[4*i+2] ? mf[i] : tick);
            r0 = step(m_cfg[1:0], 1'b1, ma[0], m_run[1] & tick, m_lo[0], m_hi[0],
                      wr_en && wr_addr == 3'd2, wr_en && wr_addr == 3'd3, wr_data);
            r1 = step(m_cfg[5:4], 1'b0, ma[1], 1'b0, m_lo[1], m_hi[1],
                      wr_en && wr_addr == 3'd4, wr_en && wr_addr == 3'd5, wr_data);
            m_flag = ((wr_en && wr_addr == 3'd1) ? wr_data[3:2] : m_flag)
                     | {r0[16] | (r1[17] & (m_cfg[1:0] != 2'd3)), r0[17]};
            if (wr_en && wr_addr == 3'd1) m_run = wr_data[1:0];
            if (wr_en && wr_addr == 3'd0) m_cfg = wr_data;
            m_lo[0] = r0[15:8]; m_hi[0] = r0[7:0];
            m_lo[1] = r1[15:8]; m_hi[1] = r1[7:0];
            m_pv = m_s1; m_s1 = m_s0; m_s0 = ext_cnt;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] a);
        logic [1:0] md;
        md = (a >= 3'd4) ? m_cfg[5:4] : m_cfg[1:0];
        if (a >= 3'd4 && md == 2'd3) return "R8";
        case (md)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rd_addr == 3'd0) chk("R1", rd_data, m_read(rd_addr));
        else if (rd_addr == 3'd1) chk("R10", rd_data, m_read(rd_addr));
        else if (rd_addr <= 3'd5) chk(mode_tag(rd_addr), rd_data, m_read(rd_addr));
        else chk("R1", rd_data, 8'd0);
        chk("R10", {6'd0, ovf_flag}, {6'd0, m_flag});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of every address
        for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'd0, "R1");

        // R4: 13-bit wrap, upper low-byte bits held
        tick = 1'b1;
        wr(3'd0, 8'h00); wr(3'd3, 8'hff); wr(3'd2, 8'hfe); wr(3'd1, 8'h01);
        idle(2);
        expect_rd(3'd2, 8'he0, "R4");
        expect_rd(3'd3, 8'h00, "R4");
        expect_rd(3'd1, 8'h05, "R4");

        // R6: 8-bit reload from high byte
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd3, 8'hf0); wr(3'd2, 8'hfe); wr(3'd1, 8'h01);
        idle(2);
        expect_rd(3'd2, 8'hf0, "R6");
        expect_rd(3'd1, 8'h05, "R6");

        // R9: write wins over increment and suppresses overflow
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h10);
        expect_rd(3'd2, 8'h10, "R9");
        wr(3'd2, 8'hff);
        wr(3'd2, 8'h33);
        expect_rd(3'd2, 8'h33, "R9");
        expect_rd(3'd1, 8'h01, "R9");

        // R7: split mode, high half driven by run1
        wr(3'd1, 8'h00); wr(3'd0, 8'h03); wr(3'd2, 8'hfe); wr(3'd3, 8'hff); wr(3'd1, 8'h02);
        idle(1);
        expect_rd(3'd3, 8'h00, "R7");
        expect_rd(3'd2, 8'hfe, "R7");
        expect_rd(3'd1, 8'h0a, "R7");

        // R8: channel 1 mode 3 holds
        wr(3'd0, 8'h33); wr(3'd4, 8'h55); wr(3'd1, 8'h03);
        idle(3);
        expect_rd(3'd4, 8'h55, "R8");

        // R11: channel 1 wrap while channel 0 split leaves flag1 clear
        wr(3'd0, 8'h13); wr(3'd1, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'hff); wr(3'd5, 8'hff); wr(3'd1, 8'h02);
        idle(1);
        expect_rd(3'd4, 8'h00, "R11");
        expect_rd(3'd5, 8'h00, "R11");
        expect_rd(3'd1, 8'h02, "R11");

        // R2: gate against interrupt level; R5: 16-bit wrap
        wr(3'd1, 8'h00); wr(3'd0, 8'h09);
        irq_act_hi = 2'b01; ext_irq = 2'b00;
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        idle(3);
        expect_rd(3'd2, 8'h00, "R2");
        ext_irq = 2'b01;
        idle(3);
        expect_rd(3'd2, 8'h03, "R2");
        wr(3'd3, 8'hff); wr(3'd2, 8'hff);
        idle(1);
        expect_rd(3'd2, 8'h00, "R5");
        expect_rd(3'd3, 8'h00, "R5");
        expect_rd(3'd1, 8'h05, "R5");

        // R3: external pin falling edge, counted on third low sample
        wr(3'd1, 8'h00); wr(3'd0, 8'h05);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        idle(3);
        expect_rd(3'd2, 8'h00, "R3");
        ext_cnt[0] = 1'b0;
        idle(2);
        expect_rd(3'd2, 8'h00, "R3");
        idle(1);
        expect_rd(3'd2, 8'h01, "R3");
        idle(5);
        expect_rd(3'd2, 8'h01, "R3");

        // Random phase checked against the model
        for (int n = 0; n < 20000; n++) begin
            tick = ($urandom % 2) == 0;
            if ($urandom % 4 == 0) ext_cnt = 2'($urandom);
            if ($urandom % 8 == 0) ext_irq = 2'($urandom);
            if ($urandom % 64 == 0) irq_act_hi = 2'($urandom);
            rd_addr = 3'($urandom);
            wr_en = ($urandom % 6) == 0;
            wr_addr = 3'($urandom);
            wr_data = 8'($urandom);
            if (wr_addr == 3'd1 && ($urandom % 4 != 0)) wr_data[1:0] = 2'b11;
            if (wr_addr >= 3'd2 && ($urandom % 2 == 0)) wr_data = 8'hfd | 8'($urandom % 3);
            cyc();
        end
        wr_en = 1'b0;
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule